// File: doc/BRIEF.md
# Loss-of-Signal Monitor with Change Interrupt

This block watches a serial receive bit stream, taking one data bit on each cycle where a bit-valid strobe is high. It tracks a loss-of-signal alarm. The alarm is raised once a long unbroken run of zero bits has arrived. It is dropped only after a whole window of valid bits has passed in which no short run of zeros was seen. A live status output always shows the present alarm state.

Every rise and every fall of the alarm sets a sticky change flag. A microprocessor clears the flag by pulsing a read strobe, which stands for a read of the status. If a new change arrives in the same cycle as the read, the flag stays set, so no event is lost. The interrupt output is the change flag gated by an enable input.

The reset input is asserted asynchronously and released through a two-stage synchronizer. The state machine therefore leaves reset two clock edges after `rst_n` rises.

Top module: `los_monitor`

## Requirements
- R1: After reset, `los_status`, `los_chg` and `irq` are all 0.
- R2: With the alarm off, the 32nd consecutive valid zero bit sets `los_status` at the clock edge that samples it. A one bit restarts the count, so 31 zeros followed by a one do not raise the alarm.
- R3: Bits are taken only on cycles with `bit_vld` = 1. Cycles with `bit_vld` = 0 leave the zero run, the exit window and the alarm state unchanged, whatever `bit_in` holds.
- R4: With the alarm on, `los_status` clears at the edge that samples the 32nd valid bit counted since the alarm was set or since the window last restarted. The window restarts, without counting the bit, whenever a valid zero extends a zero run to 4 or more.
- R5: Runs of 1 to 3 zeros inside the exit window count as ordinary bits and do not delay the exit.
- R6: `los_chg` becomes 1 at the same edge where `los_status` rises or falls.
- R7: A cycle with `rd_stb` = 1 and no alarm change clears `los_chg` at that edge. Without a read, `los_chg` holds its value.
- R8: If the alarm changes in the same cycle as `rd_stb` = 1, `los_chg` is 1 after that edge.
- R9: `irq` equals `los_chg` AND `irq_en` at all times. It is combinational from `irq_en`.
- R10: `rd_stb` has no effect on `los_status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bit_vld | input | 1 | High when `bit_in` carries a received bit this cycle |
| bit_in | input | 1 | Received data bit |
| rd_stb | input | 1 | One-cycle pulse marking a read of the change flag (clears it) |
| irq_en | input | 1 | Interrupt enable |
| los_status | output | 1 | Live loss-of-signal state |
| los_chg | output | 1 | Sticky change flag, cleared on read |
| irq | output | 1 | Interrupt request: `los_chg` AND `irq_en` |

## Verification
The assertions assume that `bit_vld`, `bit_in` and `rd_stb` are synchronous to `clk` and hold known values once reset is released. They also assume that `bit_in` matters only when `bit_vld` is high. The stimulus changes every input only at the falling clock edge and drives plain 0/1 values from the first cycle. It deliberately drives a one on `bit_in` during idle cycles, so that an ignored bit would show up as a wrong result. Random phases switch between sparse, dense and near-total zero densities, so the stream enters and leaves the alarm many times.

// File: rtl/los_pkg.sv
package los_pkg;

  typedef enum logic {
    LINK_UP   = 1'b0,
    LINK_LOST = 1'b1
  } link_e;

  typedef struct packed {
    logic vld;
    logic zero;
  } rx_bit_t;

endpackage

// File: rtl/los_rst_sync.sv
module los_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/los_zero_run.sv
module los_zero_run
  import los_pkg::*;
#(
  parameter int RUN_MAX   = 32,
  parameter int SHORT_RUN = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  rx_bit_t rx,
  output logic    long_hit,
  output logic    short_hit
);

  localparam int CW = $clog2(RUN_MAX + 1);
  localparam logic [CW-1:0] RUN_TOP   = CW'(RUN_MAX);
  localparam logic [CW-1:0] LONG_M1   = CW'(RUN_MAX - 1);
  localparam logic [CW-1:0] SHORT_M1  = CW'(SHORT_RUN - 1);

  logic [CW-1:0] run_q;
  logic [CW-1:0] run_d;

  always_comb begin
    run_d = run_q;
    if (rx.vld) begin
      if (!rx.zero)            run_d = '0;
      else if (run_q != RUN_TOP) run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  always_comb begin
    long_hit  = rx.vld && rx.zero && (run_q >= LONG_M1);
    short_hit = rx.vld && rx.zero && (run_q >= SHORT_M1);
  end

  // R2
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_TOP);

  // R3
  run_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx.vld |=> $stable(run_q));

  // R2
  run_one_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx.vld && !rx.zero) |=> (run_q == '0));

endmodule

// File: rtl/los_alarm_fsm.sv
module los_alarm_fsm
  import los_pkg::*;
#(
  parameter int WINDOW = 32
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rx_vld,
  input  logic  long_hit,
  input  logic  short_hit,
  output link_e state,
  output logic  set_evt,
  output logic  clr_evt
);

  localparam int WW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam logic [WW-1:0] WIN_LAST = WW'(WINDOW - 1);

  link_e         state_q, state_d;
  logic [WW-1:0] win_q, win_d;
  logic          lost;

  always_comb begin
    state_d = state_q;
    win_d   = win_q;
    set_evt = 1'b0;
    clr_evt = 1'b0;
    case (state_q)
      LINK_UP: begin
        win_d = '0;
        if (long_hit) begin
          state_d = LINK_LOST;
          set_evt = 1'b1;
        end
      end
      LINK_LOST: begin
        if (rx_vld) begin
          if (short_hit) begin
            win_d = '0;
          end else if (win_q == WIN_LAST) begin
            win_d   = '0;
            state_d = LINK_UP;
            clr_evt = 1'b1;
          end else begin
            win_d = win_q + 1'b1;
          end
        end
      end
      default: begin
        state_d = LINK_UP;
        win_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LINK_UP;
      win_q   <= '0;
    end else begin
      state_q <= state_d;
      win_q   <= win_d;
    end
  end

  assign state = state_q;
  assign lost  = (state_q == LINK_LOST);

  // R3
  alarm_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_vld |=> ($stable(lost) && $stable(win_q)));

  // R2
  alarm_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost) |-> $past(long_hit));

  // R4
  alarm_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lost) |-> $past(rx_vld && !short_hit));

  // R4
  window_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lost |-> (win_q == '0));

endmodule

// File: rtl/los_chg_latch.sv
module los_chg_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic rd,
  output logic flag
);

  logic flag_q, flag_d;

  always_comb flag_d = evt || (flag_q && !rd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  // R6
  chg_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag_q);

  // R7
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !evt) |=> !flag_q);

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !rd) |=> flag_q);

endmodule

// File: rtl/los_monitor.sv
module los_monitor
  import los_pkg::*;
#(
  parameter int ENTRY_ZEROS   = 32,
  parameter int EXIT_WINDOW   = 32,
  parameter int EXIT_ZERO_RUN = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_in,
  input  logic rd_stb,
  input  logic irq_en,
  output logic los_status,
  output logic los_chg,
  output logic irq
);

  logic    rst_sync_n;
  rx_bit_t rx;
  logic    long_hit, short_hit;
  link_e   state;
  logic    set_evt, clr_evt;
  logic    chg_evt;

  los_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    rx.vld  = bit_vld;
    rx.zero = !bit_in;
  end

  los_zero_run #(
    .RUN_MAX   (ENTRY_ZEROS),
    .SHORT_RUN (EXIT_ZERO_RUN)
  ) u_run (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rx        (rx),
    .long_hit  (long_hit),
    .short_hit (short_hit)
  );

  los_alarm_fsm #(.WINDOW(EXIT_WINDOW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rx_vld    (bit_vld),
    .long_hit  (long_hit),
    .short_hit (short_hit),
    .state     (state),
    .set_evt   (set_evt),
    .clr_evt   (clr_evt)
  );

  assign chg_evt = set_evt || clr_evt;

  los_chg_latch u_chg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .evt   (chg_evt),
    .rd    (rd_stb),
    .flag  (los_chg)
  );

  assign los_status = (state == LINK_LOST);
  assign irq        = los_chg && irq_en;

  // R10
  read_no_state_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_stb && !bit_vld) |=> $stable(los_status));

  // R6
  change_flags_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (los_status != $past(los_status)) |-> los_chg);

endmodule

// File: tb/los_monitor_test.sv
`timescale 1ns/1ps
module los_monitor_test;

  logic clk = 1'b0;
  logic rst_n;
  logic bit_vld, bit_in, rd_stb, irq_en;
  logic los_status, los_chg, irq;

  int checks = 0;
  int errors = 0;

  // reference state
  int  m_run;
  int  m_win;
  bit  m_los;
  bit  m_flag;

  always #2.5 clk = ~clk;

  los_monitor uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_vld    (bit_vld),
    .bit_in     (bit_in),
    .rd_stb     (rd_stb),
    .irq_en     (irq_en),
    .los_status (los_status),
    .los_chg    (los_chg),
    .irq        (irq)
  );

  task automatic check(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  function automatic bit model_step(input bit v, input bit b);
    bit evt = 1'b0;
    int nrun;
    if (v) begin
      nrun = b ? 0 : ((m_run < 32) ? m_run + 1 : 32);
      if (!m_los) begin
        m_win = 0;
        if (nrun >= 32) begin
          m_los = 1'b1;
          evt = 1'b1;
        end
      end else begin
        if (!b && nrun >= 4) m_win = 0;
        else if (m_win + 1 == 32) begin
          m_win = 0;
          m_los = 1'b0;
          evt = 1'b1;
        end else m_win = m_win + 1;
      end
      m_run = nrun;
    end
    return evt;
  endfunction

  task automatic step(input bit v, input bit b, input bit r, input bit e, input string tag);
    bit evt;
    @(negedge clk);
    bit_vld = v; bit_in = b; rd_stb = r; irq_en = e;
    evt = model_step(v, b);
    m_flag = evt || (m_flag && !r);
    @(posedge clk);
    #1;
    check(los_status, m_los, tag, "los_status");
    check(los_chg, m_flag, (evt ? "R6" : (r ? "R7" : tag)), "los_chg");
    check(irq, m_flag && e, "R9", "irq");
  endtask

  task automatic run_all();
    int zero_pct;
    rst_n = 1'b0; bit_vld = 1'b0; bit_in = 1'b1; rd_stb = 1'b0; irq_en = 1'b1;
    m_run = 0; m_win = 0; m_los = 1'b0; m_flag = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(los_status, 1'b0, "R1", "los_status after reset");
    check(los_chg, 1'b0, "R1", "los_chg after reset");
    check(irq, 1'b0, "R1", "irq after reset");

    // R2: 31 zeros then a one: no alarm
    for (int i = 0; i < 31; i++) step(1, 0, 0, 1, "R2");
    step(1, 1, 0, 1, "R2");
    // R3: idle cycles carrying ones must not break the zero run
    for (int i = 0; i < 20; i++) step(1, 0, 0, 1, "R3");
    for (int i = 0; i < 15; i++) step(0, 1, 0, 1, "R3");
    for (int i = 0; i < 12; i++) step(1, 0, 0, 1, "R3");
    // R7 / R10: read clears flag, alarm unchanged
    step(0, 1, 1, 0, "R10");
    step(0, 1, 0, 1, "R7");
    // R4: ones then a four-zero run restarts the window
    for (int i = 0; i < 20; i++) step(1, 1, 0, 1, "R4");
    for (int i = 0; i < 4; i++)  step(1, 0, 0, 1, "R4");
    // R5: repeating 1,0,0,0 pattern exits after 32 bits
    for (int i = 0; i < 31; i++) step(1, (i % 4) == 0, 0, 1, "R5");
    // R8: exit with simultaneous read
    step(1, 0, 1, 1, "R8");
    step(0, 1, 0, 0, "R7");
    step(0, 1, 1, 1, "R7");

    // constrained random phases
    zero_pct = 30;
    for (int i = 0; i < 20000; i++) begin
      if ((i % 256) == 0) begin
        case ($urandom % 3)
          0: zero_pct = 30;
          1: zero_pct = 85;
          default: zero_pct = 99;
        endcase
      end
      step(($urandom % 100) < 80, ($urandom % 100) >= zero_pct,
           ($urandom % 100) < 5, $urandom % 2, "R4");
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    fork
      run_all();
      begin
        #(1_000_000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule